// File: doc/BRIEF.md
# Pipeline Hazard Stall Calculator

This block sits beside the issue stage of an in-order core and decides how long each instruction must wait before it may issue. For every instruction offered on a valid/ready handshake it receives the register operands, the memory-access and jump flags, the multiply flag, the range of a multi-register load or store and its base address, and the low bits of the program counter. It holds the instruction (ready low) for as many cycles as the hazards require, then accepts it and reports the stall cycles it spent, split by cause.

History is kept as bitmasks over a 32-position register space. Each accepted instruction and each stall cycle ages the history by one slot. A stall cycle enters an empty mask, so waiting moves older writers further away. Hazards are evaluated again in every cycle until none is left. Two positions that belong to constant-zero registers are used instead as markers for "was a jump" and "wrote memory". After the hazards clear, extra cycles are added for a multi-register transfer that crosses 32-byte line boundaries.

Top module: `hazard_stall_calc`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all history is empty, rsp_valid is low, every cause counter is zero, and in_ready is high for an instruction with no hazard.
- R2: History ages only on an accepted instruction (its own masks enter) or on a stall cycle (in_valid high, in_ready low; empty masks enter). Cycles with in_valid low leave it unchanged.
- R3: Register index k (5 bits) names mask bit k: 0-15 general, 16+n special register n. A jump sets bit 16, a memory write sets bit 20, a multiply sets bit 23, and a destination write sets its own bit, except that a write to register 16 or 20 sets nothing.
- R4: A source (src_en) or destination-input (dsti_en) register loaded by a multi-register load 1, 2 or 3 instructions back gives 3, 2 or 1 stall cycles (cause 0). The load covers registers 0..mv_lim only.
- R5: An address register (addr_en) modified by the previous instruction gives 1 stall cycle (cause 1).
- R6: A memory read stalls while a memory write lies 1 or 2 slots back: 2 cycles after an adjacent write, 1 cycle when one instruction lies between (cause 2).
- R7: A jump-to-register whose register was modified 1 or 2 back stalls 2 or 1 cycles (cause 3).
- R8: A multiply whose src_reg or dsti_reg was modified by the previous instruction stalls 1 cycle (cause 4).
- R9: Right after a jump, a 16-bit immediate fetch with pc_lo == 4'hF, or a 32-bit one with pc_lo == 4'hE, stalls 1 cycle (cause 5). Other pc_lo values do not stall.
- R10: A multi-register store of registers 0..mv_lim stalls 2 cycles if any of them was modified 1 back, else 1 cycle if any was modified 2 back (cause 6).
- R11: After the hazard stalls, a multi-register load or store adds one cycle (cause 7) for each 32-byte line boundary crossed by bytes mv_base to mv_base+4*(mv_lim+1)-1, at most 2.
- R12: One cycle after acceptance rsp_valid pulses. rsp_total gives the stall cycles. rsp_cause[2k+1:2k] gives the cycles charged to cause k. Each stall cycle is charged to the lowest-numbered active cause.
- R13: cause_cnt[k*CNT_W +: CNT_W] counts the stall cycles charged to cause k over all instructions and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle |
| src_en | input | 1 | Source register in use |
| src_reg | input | 5 | Source register index |
| dsti_en | input | 1 | Destination read as input |
| dsti_reg | input | 5 | Destination-input register index |
| dsto_en | input | 1 | Destination register written |
| dsto_reg | input | 5 | Written register index |
| addr_en | input | 1 | Memory address register in use |
| addr_reg | input | 5 | Address register index |
| mem_rd | input | 1 | Instruction reads memory |
| mem_wr | input | 1 | Instruction writes memory |
| jump | input | 1 | Instruction is a jump |
| jreg_en | input | 1 | Jump target taken from a register |
| jreg | input | 5 | Jump target register index |
| mul | input | 1 | Instruction multiplies |
| imm16 | input | 1 | 16-bit immediate fetched |
| imm32 | input | 1 | 32-bit immediate fetched |
| pc_lo | input | 4 | Program counter bits 4:1 |
| mv_ld | input | 1 | Multi-register load |
| mv_st | input | 1 | Multi-register store |
| mv_lim | input | 4 | Last register of the transfer |
| mv_base | input | 32 | Transfer base byte address |
| rsp_valid | output | 1 | Per-instruction result valid |
| rsp_total | output | 3 | Stall cycles of the instruction |
| rsp_cause | output | 16 | Stall cycles per cause, 2 bits each |
| cause_cnt | output | 8*CNT_W | Saturating stall totals per cause |

## Verification
The bench builds the block with CNT_W = 3 and keeps all other parameters at their defaults. With a 3-bit counter, the load-destination cause goes past its limit of 7 within a few dozen instructions, so the saturation in R13 is reached. The default 32-byte line and 16-register transfer still allow a store of all registers from an address just below a line boundary to cross two boundaries.

// File: rtl/hazard_stall_calc.sv
module hazard_stall_calc #(
  parameter int MASK_W  = 32,
  parameter int NGPR    = 16,
  parameter int ADDR_W  = 32,
  parameter int LINE_LG = 5,
  parameter int CNT_W   = 16,
  parameter int JMP_BIT = 16,
  parameter int WR_BIT  = 20,
  parameter int MOF_BIT = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  src_en,
  input  logic [4:0]            src_reg,
  input  logic                  dsti_en,
  input  logic [4:0]            dsti_reg,
  input  logic                  dsto_en,
  input  logic [4:0]            dsto_reg,
  input  logic                  addr_en,
  input  logic [4:0]            addr_reg,
  input  logic                  mem_rd,
  input  logic                  mem_wr,
  input  logic                  jump,
  input  logic                  jreg_en,
  input  logic [4:0]            jreg,
  input  logic                  mul,
  input  logic                  imm16,
  input  logic                  imm32,
  input  logic [3:0]            pc_lo,
  input  logic                  mv_ld,
  input  logic                  mv_st,
  input  logic [3:0]            mv_lim,
  input  logic [31:0]           mv_base,
  output logic                  rsp_valid,
  output logic [2:0]            rsp_total,
  output logic [15:0]           rsp_cause,
  output logic [8*CNT_W-1:0]    cause_cnt
);
  localparam int NCAUSE = 8;
  localparam int LINE_W = ADDR_W - LINE_LG;

  logic [MASK_W-1:0] mod1, mod2, ld1, ld2, ld3;
  logic [MASK_W-1:0] ld_any, mod12, lim_mask, new_mod, new_ld;
  logic [NCAUSE-1:0] haz;
  logic              haz_any, bubble, accept;
  logic [1:0]        strad_cnt, need;
  logic [2:0]        bub_idx, acc_total;
  logic [15:0]       acc;
  logic [ADDR_W-1:0] span_end;
  logic [LINE_W-1:0] line_diff;

  assign ld_any   = ld1 | ld2 | ld3;
  assign mod12    = mod1 | mod2;
  assign lim_mask = {MASK_W{1'b1}} >> (MASK_W - 1 - int'(mv_lim));

  assign haz[0] = (src_en & ld_any[src_reg]) | (dsti_en & ld_any[dsti_reg]);
  assign haz[1] = addr_en & mod1[addr_reg];
  assign haz[2] = mem_rd & (mod1[WR_BIT] | mod2[WR_BIT]);
  assign haz[3] = jreg_en & mod12[jreg];
  assign haz[4] = mul & (mod1[src_reg] | mod1[dsti_reg]);
  assign haz[5] = mod1[JMP_BIT] & ((imm16 & (pc_lo == 4'hF)) | (imm32 & (pc_lo == 4'hE)));
  assign haz[6] = mv_st & (|(mod12 & lim_mask));
  assign haz[7] = 1'b0;
  assign haz_any = |haz;

  assign span_end  = mv_base + ADDR_W'({mv_lim, 2'b11});
  assign line_diff = span_end[ADDR_W-1:LINE_LG] - mv_base[ADDR_W-1:LINE_LG];
  assign need      = !(mv_ld | mv_st) ? 2'd0 :
                     (line_diff > LINE_W'(2)) ? 2'd2 : line_diff[1:0];

  assign in_ready = !haz_any && (strad_cnt == need);
  assign bubble   = in_valid && !in_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    bub_idx = 3'd7;
    for (int k = NCAUSE - 2; k >= 0; k--)
      if (haz[k]) bub_idx = 3'(k);
  end

  always_comb begin
    new_mod = '0;
    if (dsto_en && int'(dsto_reg) != JMP_BIT && int'(dsto_reg) != WR_BIT)
      new_mod[dsto_reg] = 1'b1;
    if (jump)   new_mod[JMP_BIT] = 1'b1;
    if (mem_wr) new_mod[WR_BIT]  = 1'b1;
    if (mul)    new_mod[MOF_BIT] = 1'b1;
    if (mv_ld)  new_mod = new_mod | lim_mask;
    new_ld = mv_ld ? lim_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod1 <= '0; mod2 <= '0;
      ld1 <= '0; ld2 <= '0; ld3 <= '0;
      strad_cnt <= '0;
      acc <= '0; acc_total <= '0;
      rsp_valid <= 1'b0; rsp_total <= '0; rsp_cause <= '0;
      cause_cnt <= '0;
    end else begin
      rsp_valid <= accept;
      if (bubble) begin
        mod1 <= '0; mod2 <= mod1;
        ld1 <= '0; ld2 <= ld1; ld3 <= ld2;
        if (!haz_any) strad_cnt <= strad_cnt + 2'd1;
        if (acc_total != 3'd7) acc_total <= acc_total + 3'd1;
        for (int k = 0; k < NCAUSE; k++) begin
          if (bub_idx == 3'(k)) begin
            if (acc[2*k +: 2] != 2'd3) acc[2*k +: 2] <= acc[2*k +: 2] + 2'd1;
            if (cause_cnt[k*CNT_W +: CNT_W] != {CNT_W{1'b1}})
              cause_cnt[k*CNT_W +: CNT_W] <= cause_cnt[k*CNT_W +: CNT_W] + CNT_W'(1);
          end
        end
      end else if (accept) begin
        mod1 <= new_mod; mod2 <= mod1;
        ld1 <= new_ld; ld2 <= ld1; ld3 <= ld2;
        strad_cnt <= '0;
        rsp_total <= acc_total;
        rsp_cause <= acc;
        acc <= '0; acc_total <= '0;
      end
    end
  end

  a_r2_bubble_empty: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (mod1 == '0 && ld1 == '0));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !in_valid) |=> ($stable(mod1) && $stable(mod2) && $stable(ld3)));

  a_r3_zero_reg_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dsto_en && int'(dsto_reg) == WR_BIT && !mem_wr) |=> !mod1[WR_BIT]);

  a_r12_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_total <= 3'd5));

  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !in_valid) |=> !rsp_valid);

  for (genvar g = 0; g < NCAUSE; g++) begin : g_cnt_chk
    a_r13_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (cause_cnt[g*CNT_W +: CNT_W] >= $past(cause_cnt[g*CNT_W +: CNT_W])));
  end
endmodule

// File: tb/hazard_stall_calc_tb_top.sv
module hazard_stall_calc_tb_top;
  localparam int CW = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid, in_ready, src_en, dsti_en, dsto_en, addr_en, mem_rd, mem_wr;
  logic jump, jreg_en, mul, imm16, imm32, mv_ld, mv_st, rsp_valid;
  logic [4:0] src_reg, dsti_reg, dsto_reg, addr_reg, jreg;
  logic [3:0] pc_lo, mv_lim;
  logic [31:0] mv_base;
  logic [2:0] rsp_total;
  logic [15:0] rsp_cause;
  logic [8*CW-1:0] cause_cnt;

  int checks = 0, errors = 0;
  int exp_cnt [8];
  logic [18:0] expq [$];
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_stall_calc #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_en(src_en), .src_reg(src_reg), .dsti_en(dsti_en), .dsti_reg(dsti_reg),
    .dsto_en(dsto_en), .dsto_reg(dsto_reg), .addr_en(addr_en), .addr_reg(addr_reg),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .jump(jump), .jreg_en(jreg_en), .jreg(jreg),
    .mul(mul), .imm16(imm16), .imm32(imm32), .pc_lo(pc_lo), .mv_ld(mv_ld),
    .mv_st(mv_st), .mv_lim(mv_lim), .mv_base(mv_base), .rsp_valid(rsp_valid),
    .rsp_total(rsp_total), .rsp_cause(rsp_cause), .cause_cnt(cause_cnt));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cv(int k, int n);
    return 16'(n << (2 * k));
  endfunction

  task automatic clr;
    in_valid = 0; src_en = 0; dsti_en = 0; dsto_en = 0; addr_en = 0;
    mem_rd = 0; mem_wr = 0; jump = 0; jreg_en = 0; mul = 0; imm16 = 0; imm32 = 0;
    mv_ld = 0; mv_st = 0; src_reg = 0; dsti_reg = 0; dsto_reg = 0; addr_reg = 0;
    jreg = 0; pc_lo = 0; mv_lim = 0; mv_base = 0;
  endtask

  // offer the instruction set up by the caller; count stall cycles
  task automatic go(string req, int tot, logic [15:0] cz);
    int n;
    expq.push_back({tot[2:0], cz});
    for (int k = 0; k < 8; k++) begin
      exp_cnt[k] += int'(cz[2*k +: 2]);
      if (exp_cnt[k] > 7) exp_cnt[k] = 7;
    end
    in_valid = 1;
    #1;
    n = 0;
    while (!in_ready && n < 20) begin
      @(negedge clk); #1; n++;
    end
    chk({req, " stall cycles"}, n, tot);
    @(posedge clk);
    @(negedge clk);
    clr;
  endtask

  task automatic nop3;
    for (int i = 0; i < 3; i++) begin clr; go("flush", 0, 16'd0); end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual unexpected response expected none");
      end else begin
        logic [18:0] e;
        e = expq.pop_front();
        chk("R12 rsp_total", int'(rsp_total), int'(e[18:16]));
        chk("R12 rsp_cause", int'(rsp_cause), int'(e[15:0]));
      end
    end
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr;
    for (int k = 0; k < 8; k++) exp_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 cause_cnt", int'(cause_cnt), 0);
    @(negedge clk);

    // R4 load-destination distances
    mv_ld = 1; mv_lim = 3; go("R4", 0, 0);
    src_en = 1; src_reg = 2; go("R4 1back", 3, cv(0, 3)); nop3;
    mv_ld = 1; mv_lim = 3; go("R4", 0, 0); go("R4 nop", 0, 0);
    src_en = 1; src_reg = 1; go("R4 2back", 2, cv(0, 2)); nop3;
    mv_ld = 1; mv_lim = 3; go("R4", 0, 0); go("R4 nop", 0, 0); go("R4 nop", 0, 0);
    dsti_en = 1; dsti_reg = 0; go("R4 3back", 1, cv(0, 1)); nop3;
    mv_ld = 1; mv_lim = 3; go("R4", 0, 0);
    src_en = 1; src_reg = 5; go("R4 outside range", 0, 0); nop3;

    // R5 address register
    dsto_en = 1; dsto_reg = 7; go("R5", 0, 0);
    addr_en = 1; addr_reg = 7; go("R5 1back", 1, cv(1, 1)); nop3;
    dsto_en = 1; dsto_reg = 7; go("R5", 0, 0); go("R5 nop", 0, 0);
    addr_en = 1; addr_reg = 7; go("R5 2back", 0, 0); nop3;

    // R6 read after memory write
    mem_wr = 1; go("R6", 0, 0);
    mem_rd = 1; go("R6 1back", 2, cv(2, 2)); nop3;
    mem_wr = 1; go("R6", 0, 0); go("R6 nop", 0, 0);
    mem_rd = 1; go("R6 2back", 1, cv(2, 1)); nop3;

    // R7 jump to register
    dsto_en = 1; dsto_reg = 9; go("R7", 0, 0);
    jreg_en = 1; jreg = 9; go("R7 1back", 2, cv(3, 2)); nop3;
    dsto_en = 1; dsto_reg = 9; go("R7", 0, 0); go("R7 nop", 0, 0);
    jreg_en = 1; jreg = 9; go("R7 2back", 1, cv(3, 1)); nop3;

    // R8 multiply, then the overflow register bit (R3)
    dsto_en = 1; dsto_reg = 4; go("R8", 0, 0);
    mul = 1; src_reg = 4; go("R8 src 1back", 1, cv(4, 1));
    jreg_en = 1; jreg = 23; go("R3 mul marks bit 23", 2, cv(3, 2)); nop3;

    // R9 immediate after jump
    jump = 1; go("R9", 0, 0);
    imm16 = 1; pc_lo = 4'hF; go("R9 imm16 F", 1, cv(5, 1)); nop3;
    jump = 1; go("R9", 0, 0);
    imm16 = 1; pc_lo = 4'hE; go("R9 imm16 E", 0, 0); nop3;
    jump = 1; go("R9", 0, 0);
    imm32 = 1; pc_lo = 4'hE; go("R9 imm32 E", 1, cv(5, 1)); nop3;
    jump = 1; go("R9", 0, 0);
    imm32 = 1; pc_lo = 4'hF; go("R9 imm32 F", 0, 0); nop3;

    // R3 zero-register writes set no marker
    dsto_en = 1; dsto_reg = 16; go("R3", 0, 0);
    imm16 = 1; pc_lo = 4'hF; go("R3 reg16 no jump mark", 0, 0); nop3;
    dsto_en = 1; dsto_reg = 20; go("R3", 0, 0);
    mem_rd = 1; go("R3 reg20 no write mark", 0, 0); nop3;
    dsto_en = 1; dsto_reg = 18; go("R3", 0, 0);
    jreg_en = 1; jreg = 18; go("R3 special reg", 2, cv(3, 2)); nop3;

    // R10 store of registers 0..L
    dsto_en = 1; dsto_reg = 2; go("R10", 0, 0);
    mv_st = 1; mv_lim = 3; go("R10 1back", 2, cv(6, 2)); nop3;
    dsto_en = 1; dsto_reg = 2; go("R10", 0, 0); go("R10 nop", 0, 0);
    mv_st = 1; mv_lim = 3; go("R10 2back", 1, cv(6, 1)); nop3;
    dsto_en = 1; dsto_reg = 5; go("R10", 0, 0);
    mv_st = 1; mv_lim = 3; go("R10 outside range", 0, 0); nop3;

    // R11 line crossings
    mv_ld = 1; mv_lim = 3; mv_base = 32'h1C; go("R11 load one line", 1, cv(7, 1)); nop3;
    mv_st = 1; mv_lim = 15; mv_base = 32'h1C; go("R11 store two lines", 2, cv(7, 2)); nop3;
    mv_st = 1; mv_lim = 7; mv_base = 32'h20; go("R11 aligned", 0, 0); nop3;
    dsto_en = 1; dsto_reg = 2; go("R11", 0, 0);
    mv_st = 1; mv_lim = 15; mv_base = 32'h1C;
    go("R11 after hazard", 4, cv(6, 2) | cv(7, 2)); nop3;

    // R12 priority: load-destination beats multiply
    mv_ld = 1; mv_lim = 3; go("R12", 0, 0);
    mul = 1; src_en = 1; src_reg = 1; go("R12 priority", 3, cv(0, 3)); nop3;

    // R2 idle cycles do not age history
    dsto_en = 1; dsto_reg = 9; go("R2", 0, 0);
    repeat (5) @(negedge clk);
    jreg_en = 1; jreg = 9; go("R2 idle hold", 2, cv(3, 2)); nop3;

    @(negedge clk);
    chk("R12 queue drained", expq.size(), 0);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R13 cause_cnt[%0d]", k), int'(cause_cnt[k*CW +: CW]), exp_cnt[k]);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule